// File: doc/BRIEF.md
# Write-Once Nonvolatile Memory Timing Tick Generator

This block holds the one-time timing setup for a nonvolatile memory controller and turns the bus clock into a slower timing tick for that controller. A single 8-bit control register is written over a simple register port. The first write after reset freezes a prescale-select bit and a divisor value N, and it also sets a loaded flag. Each program or erase timing pulse in the controller lasts one tick period. A permission output tells the controller whether erase and program may start.

The tick is a one-bus-cycle enable pulse, not a separate clock. The tick rate is the bus clock divided by N+1. When the prescale bit is set, a divide-by-8 stage comes first, so the ratio becomes 8×(N+1). Software picks N so that the tick rate falls in the range of roughly 150 kHz to 200 kHz, which gives pulses of about 5 µs to 6.7 µs. Both counters stay cleared until the register has been loaded. The configuration register runs a two-state machine:
- CFG_UNLOADED is the reset state.
- The first write moves it to CFG_LOADED. That transition is named LOAD.
- CFG_LOADED holds until reset. Every later write is ignored in that state; this is the HOLD transition.

Top module: `nvm_tick_gen`

## Requirements
- R1: Following reset, `rd_data_o` reads 0x00, while both `tick_o` and `prog_allow_o` stay 0.
- R2: Bit 7 of `rd_data_o` is the loaded flag. The first write after reset sets it whatever the write data, 0x00 included, and only reset clears it.
- R3: The first write stores write-data bits 6..0. Bit 6 is prescale select and bits 5..0 are N. After that write, `rd_data_o[6:0]` returns the stored bits. Write-data bit 7 has no effect.
- R4: Any write made while the loaded flag is 1 is ignored. It changes neither `rd_data_o` nor the tick phase.
- R5: `prog_allow_o` equals the loaded flag.
- R6: `tick_o` stays 0 as long as the loaded flag is 0.
- R7: With prescale select 0, `tick_o` is 1 in loaded cycle c (the first cycle after the loading write is c=0) exactly when (c+1) is a multiple of N+1.
- R8: With prescale select 1, `tick_o` is 1 in loaded cycle c exactly when (c+1) is a multiple of 8×(N+1), and each tick lasts a single cycle.
- R9: With N=0 and prescale select 0, `tick_o` is 1 in every cycle after loading, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| wr_data | input | 8 | Write data: bit 6 is prescale select, bits 5..0 are N |
| rd_data_o | output | 8 | Register read value {loaded, prescale select, N} |
| tick_o | output | 1 | One-cycle timing enable at the divided rate |
| prog_allow_o | output | 1 | Erase/program permitted |

## Verification
The bench builds the block with its default parameters: a 6-bit divisor and a prescale ratio of 8. With these values the largest ratio, 512 bus cycles at N=63 with the prescaler on, can be covered in a short run, so the wrap of both counters at their full range is checked. Each scenario starts from its own reset. The scenarios cover the ratio-1 case, a mid-range ratio with and without the prescaler, and the largest divisor. In each one a later write is injected partway through, to show that the tick phase does not move.

// File: rtl/nvmclk_pkg.sv
package nvmclk_pkg;

    typedef enum logic {
        CFG_UNLOADED = 1'b0,
        CFG_LOADED   = 1'b1
    } cfg_state_e;

endpackage

// File: rtl/nvmclk_cfg_reg.sv
module nvmclk_cfg_reg
    import nvmclk_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W:0]   wr_fields,
    output logic             loaded,
    output logic             presel,
    output logic [DIV_W-1:0] div_n
);

    cfg_state_e     state_q;
    cfg_state_e     state_d;
    logic [DIV_W:0] fields_q;
    logic           capture;

    // next-state logic
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            CFG_UNLOADED: begin
                if (wr_en) begin
                    state_d = CFG_LOADED;   // LOAD
                    capture = 1'b1;
                end
            end
            CFG_LOADED: begin
                state_d = CFG_LOADED;       // HOLD: later writes ignored
            end
            default: state_d = CFG_UNLOADED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_UNLOADED;
        end else begin
            state_q <= state_d;
        end
    end

    // field storage, written only on the LOAD transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (capture) begin
            fields_q <= wr_fields;
        end
    end

    // outputs
    always_comb begin
        loaded = (state_q == CFG_LOADED);
        presel = fields_q[DIV_W];
        div_n  = fields_q[DIV_W-1:0];
    end

endmodule

// File: rtl/nvmclk_prescaler.sv
module nvmclk_prescaler #(
    parameter int PRE_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel,
    output logic step
);

    generate
        if (PRE_RATIO > 1) begin : g_pre
            localparam int PRE_W = $clog2(PRE_RATIO);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

            logic [PRE_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!en || !sel) begin
                    cnt_q <= '0;
                end else if (cnt_q == PRE_LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign step = sel ? (cnt_q == PRE_LAST) : 1'b1;
        end else begin : g_nopre
            logic unused_sel;
            assign unused_sel = sel ^ en;
            assign step = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/nvmclk_divider.sv
module nvmclk_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick = en & step & at_limit;

endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
    parameter int DIV_W     = 6,
    parameter int PRE_RATIO = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W+1:0] wr_data,
    output logic [DIV_W+1:0] rd_data_o,
    output logic             tick_o,
    output logic             prog_allow_o
);

    localparam int REG_W = DIV_W + 2;

    logic             loaded;
    logic             presel;
    logic [DIV_W-1:0] div_n;
    logic             step;
    logic             unused_wr_top;

    assign unused_wr_top = wr_data[REG_W-1];   // loaded flag is read-only

    nvmclk_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_fields (wr_data[REG_W-2:0]),
        .loaded    (loaded),
        .presel    (presel),
        .div_n     (div_n)
    );

    nvmclk_prescaler #(.PRE_RATIO(PRE_RATIO)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (loaded),
        .sel   (presel),
        .step  (step)
    );

    nvmclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (loaded),
        .step  (step),
        .limit (div_n),
        .tick  (tick_o)
    );

    assign rd_data_o    = {loaded, presel, div_n};
    assign prog_allow_o = loaded;

endmodule

// File: rtl/nvm_tick_gen_chk.sv
module nvm_tick_gen_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [DIV_W+1:0] rd_data_o,
    input logic             tick_o,
    input logic             prog_allow_o
);

    localparam int TOP = DIV_W + 1;

    p_first_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_data_o[TOP]) |=> rd_data_o[TOP]);

    p_loaded_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[TOP] |=> rd_data_o[TOP]);

    p_fields_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[TOP] |=> $stable(rd_data_o[TOP-1:0]));

    p_allow_is_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_allow_o == rd_data_o[TOP]);

    p_no_tick_unloaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_allow_o |-> !tick_o);

    p_single_tick_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && rd_data_o[TOP-1]) |=> !tick_o);

    p_every_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_allow_o && rd_data_o[TOP-1:0] == '0) |-> tick_o);

endmodule

bind nvm_tick_gen nvm_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_data_o    (rd_data_o),
    .tick_o       (tick_o),
    .prog_allow_o (prog_allow_o)
);

// File: tb/nvm_tick_gen_tb_top.sv
`timescale 1ns/1ps
module nvm_tick_gen_tb_top;

    typedef struct {
        logic  tick;
        logic  allow;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data_o;
    logic       tick_o;
    logic       prog_allow_o;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    nvm_tick_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data_o    (rd_data_o),
        .tick_o       (tick_o),
        .prog_allow_o (prog_allow_o)
    );

    // monitor: compare against scoreboard on the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (tick_o !== e.tick || prog_allow_o !== e.allow) begin
                errors++;
                $display("FAIL %s: tick/allow=%b%b expected %b%b at %0t",
                         e.req, tick_o, prog_allow_o, e.tick, e.allow, $time);
            end
        end
    end

    task automatic check_rd(input logic [7:0] exp, input string req);
        checks++;
        if (rd_data_o !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected %h", req, rd_data_o, exp);
        end
    endtask

    // all stimulus changes 1 ns after a rising edge
    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_rd(8'h00, "R1");
        checks++;
        if (tick_o !== 1'b0 || prog_allow_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: tick/allow=%b%b expected 00", tick_o, prog_allow_o);
        end
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    // driver: push expected tick per cycle; optional ignored write at cycle wr_at
    task automatic track(input bit loaded, input int ratio, input int n,
                         input int wr_at, input logic [7:0] wdat, input string req);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.tick  = loaded && (((i + 1) % ratio) == 0);
            e.allow = loaded;
            e.req   = req;
            sb_q.push_back(e);
            wr_en   = (i == wr_at);
            wr_data = wdat;
            @(posedge clk);
            #1;
        end
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // S1: unloaded, then load with 0x00 -> ratio 1
        do_reset();
        track(1'b0, 1, 12, -1, 8'h00, "R6");
        do_write(8'h00);
        check_rd(8'h80, "R2");
        track(1'b1, 1, 20, 5, 8'h7F, "R9");
        check_rd(8'h80, "R4");

        // S2: bit 7 written 0, N=5, no prescale -> ratio 6
        do_reset();
        do_write(8'h05);
        check_rd(8'h85, "R3");
        track(1'b1, 6, 40, 10, 8'h41, "R7");
        check_rd(8'h85, "R4");

        // S3: prescale on, N=2 -> ratio 24, bit 7 written 1
        do_reset();
        do_write(8'hC2);
        check_rd(8'hC2, "R3");
        track(1'b1, 24, 80, 30, 8'h00, "R8");
        check_rd(8'hC2, "R4");

        // S4: N=63, no prescale -> ratio 64
        do_reset();
        do_write(8'h3F);
        check_rd(8'hBF, "R7");
        track(1'b1, 64, 140, 70, 8'h40, "R7");

        // S5: largest ratio 512
        do_reset();
        do_write(8'h7F);
        check_rd(8'hFF, "R5");
        track(1'b1, 512, 1100, 600, 8'h01, "R8");
        check_rd(8'hFF, "R4");

        @(posedge clk);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule